// File: doc/BRIEF.md
# Dual-Compare Timer/Counter

This block is a 16-bit timer/counter for a processor subsystem. Software programs it through four word-wide registers: a control word, the live count and two compare limits, A and B. The counter advances on a selectable count source. That source is the system clock, the system clock divided by a fixed prescale ratio, rising edges of an asynchronous input pin (resynchronised on entry), or a one-clock pulse from another timer's rollover. This lets timers be chained as prescalers.

When the count reaches its limit it returns to zero, and a match event fires. In single-limit mode only compare A is used. The waveform pin then dips low for one clock at each match, which gives a periodic strobe or a periodic interrupt. In alternating mode the counter first runs to limit A and then to limit B. The waveform is high during the A phase and low during the B phase, so its duty cycle is A/(A+B). A read-only status bit shows which limit is active.

The block has two run modes. In free-running mode counting goes on indefinitely. In one-pass mode the enable bit clears itself after one complete sequence: one A period in single-limit mode, or the A period followed by the B period in alternating mode. An interrupt pulse can be enabled for every match. A limit of zero means a full 65536-count period.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset all four registers read zero, wave_out is 1, and irq and rollover_out are 0.
- R2: A write to address 0 (control), 1 (count), 2 (compare A) or 3 (compare B) loads that register, and rdata returns it for the address presented. The control word reads with enable at bit 0, free-run at bit 1, alternate at bit 2, source at bits 4:3, irq-enable at bit 5 and the status at bit 6. The status bit cannot be written.
- R3: In single-limit mode with compare A = N, the count goes 0, 1, ... N-1 and then returns to 0 on the next count tick. Each return to 0 is a match event.
- R4: In single-limit mode wave_out is 0 for exactly the one clock after a match and 1 otherwise.
- R5: In alternating mode the counter runs N_A ticks with status 0 and wave_out 1, then N_B ticks with status 1 and wave_out 0, and repeats.
- R6: With free-run (bit 1) clear, the enable bit clears at the match that ends a sequence. That is the A match in single-limit mode and the B match in alternating mode. The count then holds at 0.
- R7: irq is a one-clock pulse in the clock after each match (A and B) when irq-enable (bit 5) is set. irq stays 0 when bit 5 is clear.
- R8: A compare value of 0 gives a period of 65536 ticks. The count reaches 16'hFFFF and then returns to 0 with a match.
- R9: The source field selects the count tick: 0 = every clock, 1 = every PRESCALE-th clock (the phase restarts at each control write), 2 = each rising edge of ext_in after a two-flop synchroniser, 3 = each clock in which casc_in is 1.
- R10: While enable is 0, the count holds its value whatever the source inputs do.
- R11: rollover_out pulses for one clock after every match, independent of irq-enable.
- R12: Any write to the control register returns the status to the A phase (status reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| ext_in | input | 1 | Asynchronous external event input |
| casc_in | input | 1 | Rollover pulse from another timer |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt pulse on each match |
| cmp_b_active | output | 1 | Status: 1 while counting toward compare B |
| rollover_out | output | 1 | Match pulse, for chaining to another timer |

## Verification
The properties assume that a count write and a match in the same clock resolve in favour of the write. They also assume that the alternate bit changes only through a control write, which also resets the phase. The bench therefore writes the count only while the timer is disabled or well away from a limit, and reprograms the control word before changing mode. The bench keeps ext_in pulses at least three clocks wide at each level, so every edge passes through the synchroniser. It keeps casc_in pulses one clock wide with gaps, so the expected tick totals are exact.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        SRC_CLK   = 2'd0,
        SRC_PRESC = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_CASC  = 2'd3
    } src_e;

    typedef struct packed {
        logic irq_en;
        src_e src;
        logic dual;
        logic cont;
        logic en;
    } ctl_t;

    localparam int CTL_BITS   = $bits(ctl_t);
    localparam int STATUS_BIT = CTL_BITS;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_CMPA = 2'd2;
    localparam logic [1:0] ADDR_CMPB = 2'd3;

    typedef struct packed {
        logic match;
        logic seq_done;
        logic en_clr;
    } evt_t;

    function automatic logic ends_sequence(input logic dual, input logic in_b);
        return !dual || in_b;
    endfunction

endpackage

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         en_clr,
    output ctl_t         ctl_q,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output logic         ctl_wr,
    output logic         cnt_wr
);

    logic cmpa_wr;
    logic cmpb_wr;

    always_comb begin
        ctl_wr  = wr_en && (addr == ADDR_CTL);
        cnt_wr  = wr_en && (addr == ADDR_CNT);
        cmpa_wr = wr_en && (addr == ADDR_CMPA);
        cmpb_wr = wr_en && (addr == ADDR_CMPB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_t'(wdata[CTL_BITS-1:0]);
            end else if (en_clr) begin
                ctl_q.en <= 1'b0;
            end
            if (cmpa_wr) begin
                cmp_a <= wdata;
            end
            if (cmpb_wr) begin
                cmp_b <= wdata;
            end
        end
    end

endmodule

// File: rtl/dct_tick.sv
module dct_tick
    import dct_pkg::*;
#(
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  src_e src,
    input  logic ext_in,
    input  logic casc_in,
    output logic tick
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic presc_tick;
    logic ext_tick;

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PW-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst || ctl_wr) begin
                    pcnt <= '0;
                end else if (pcnt == PW'(PRESCALE - 1)) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
            assign presc_tick = (pcnt == PW'(PRESCALE - 1));
        end else begin : g_nodiv
            assign presc_tick = 1'b1;
        end
    endgenerate

    logic [SYNC_STAGES:0] sync_q;

    generate
        for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[i] <= 1'b0;
                end else if (i == 0) begin
                    sync_q[i] <= ext_in;
                end else begin
                    sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign ext_tick = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

    always_comb begin
        unique case (src)
            SRC_CLK:   tick = 1'b1;
            SRC_PRESC: tick = presc_tick;
            SRC_EXT:   tick = ext_tick;
            SRC_CASC:  tick = casc_in;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/dct_core.sv
module dct_core
    import dct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic         ctl_wr,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         in_b,
    output logic         wave_out,
    output logic         irq,
    output logic         rollover_out,
    output logic         en_clr
);

    logic [W-1:0] target;
    logic [W-1:0] last_val;
    logic         step;
    logic         in_b_n;
    evt_t         evt;

    always_comb begin
        target       = in_b ? cmp_b : cmp_a;
        last_val     = target - 1'b1;   // zero wraps to all-ones: full period
        step         = ctl.en && tick && !cnt_wr;
        evt.match    = step && (count == last_val);
        evt.seq_done = evt.match && ends_sequence(ctl.dual, in_b);
        evt.en_clr   = evt.seq_done && !ctl.cont;
        en_clr       = evt.en_clr;
        if (ctl_wr) begin
            in_b_n = 1'b0;
        end else if (evt.match && ctl.dual) begin
            in_b_n = !in_b;
        end else begin
            in_b_n = in_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count        <= '0;
            in_b         <= 1'b0;
            wave_out     <= 1'b1;
            irq          <= 1'b0;
            rollover_out <= 1'b0;
        end else begin
            if (cnt_wr) begin
                count <= wdata;
            end else if (step) begin
                count <= evt.match ? '0 : count + 1'b1;
            end
            in_b         <= in_b_n;
            wave_out     <= ctl.dual ? !in_b_n : !evt.match;
            irq          <= evt.match && ctl.irq_en;
            rollover_out <= evt.match;
        end
    end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int W           = 16,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         ext_in,
    input  logic         casc_in,
    output logic         wave_out,
    output logic         irq,
    output logic         cmp_b_active,
    output logic         rollover_out
);

    ctl_t         ctl_q;
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    logic [W-1:0] count;
    logic         ctl_wr;
    logic         cnt_wr;
    logic         en_clr;
    logic         tick;
    logic         in_b;
    logic [W-1:0] ctl_rd;

    dct_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .en_clr (en_clr),
        .ctl_q  (ctl_q),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .ctl_wr (ctl_wr),
        .cnt_wr (cnt_wr)
    );

    dct_tick #(.PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .ctl_wr  (ctl_wr),
        .src     (ctl_q.src),
        .ext_in  (ext_in),
        .casc_in (casc_in),
        .tick    (tick)
    );

    dct_core #(.W(W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .ctl          (ctl_q),
        .ctl_wr       (ctl_wr),
        .cnt_wr       (cnt_wr),
        .wdata        (wdata),
        .cmp_a        (cmp_a),
        .cmp_b        (cmp_b),
        .tick         (tick),
        .count        (count),
        .in_b         (in_b),
        .wave_out     (wave_out),
        .irq          (irq),
        .rollover_out (rollover_out),
        .en_clr       (en_clr)
    );

    always_comb begin
        ctl_rd                 = '0;
        ctl_rd[CTL_BITS-1:0]   = ctl_q;
        ctl_rd[STATUS_BIT]     = in_b;
        unique case (addr)
            ADDR_CTL:  rdata = ctl_rd;
            ADDR_CNT:  rdata = count;
            ADDR_CMPA: rdata = cmp_a;
            default:   rdata = cmp_b;
        endcase
    end

    assign cmp_b_active = in_b;

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         cont,
    input logic         dual,
    input logic         irq_en,
    input logic         ctl_wr,
    input logic         cnt_wr,
    input logic [W-1:0] count,
    input logic         status,
    input logic         wave_out,
    input logic         irq,
    input logic         rollover_out
);

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));

    a_r11_irq_with_roll: assert property (@(posedge clk) disable iff (rst)
        irq |-> rollover_out);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> $stable(count));

    a_r5_wave_phase: assert property (@(posedge clk) disable iff (rst)
        $past(dual) |-> (wave_out == !status));

    a_r5_single_status: assert property (@(posedge clk) disable iff (rst)
        $past(!dual) |-> !status);

    a_r4_low_on_match: assert property (@(posedge clk) disable iff (rst)
        ($past(!dual) && !wave_out) |-> rollover_out);

    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (rollover_out && !$past(cnt_wr)) |-> (count == '0));

    a_r6_one_pass: assert property (@(posedge clk) disable iff (rst)
        (rollover_out && $past(!cont) && $past(!dual) && $past(!ctl_wr)) |-> !en);

endmodule

bind dual_cmp_timer dct_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (ctl_q.en),
    .cont         (ctl_q.cont),
    .dual         (ctl_q.dual),
    .irq_en       (ctl_q.irq_en),
    .ctl_wr       (ctl_wr),
    .cnt_wr       (cnt_wr),
    .count        (count),
    .status       (in_b),
    .wave_out     (wave_out),
    .irq          (irq),
    .rollover_out (rollover_out)
);

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ext_in = 1'b0;
    logic        casc_in = 1'b0;
    logic        wave_out;
    logic        irq;
    logic        cmp_b_active;
    logic        rollover_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = !clk;

    dual_cmp_timer dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .ext_in       (ext_in),
        .casc_in      (casc_in),
        .wave_out     (wave_out),
        .irq          (irq),
        .cmp_b_active (cmp_b_active),
        .rollover_out (rollover_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] v;
        peek(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        chk_reg("R1 ctl", 2'd0, 16'h0000);
        chk_reg("R1 cnt", 2'd1, 16'h0000);
        chk_reg("R1 cmpa", 2'd2, 16'h0000);
        chk_reg("R1 cmpb", 2'd3, 16'h0000);
        check("R1 wave", {15'd0, wave_out}, 16'd1);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 roll", {15'd0, rollover_out}, 16'd0);
    endtask

    task automatic t_regs;
        wr(2'd3, 16'hBEEF);
        chk_reg("R2 cmpb", 2'd3, 16'hBEEF);
        wr(2'd2, 16'h1234);
        chk_reg("R2 cmpa", 2'd2, 16'h1234);
        wr(2'd0, 16'h007C);
        chk_reg("R2 ctl status not writable", 2'd0, 16'h003C);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_single;
        wr(2'd2, 16'd5);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0023);
        chk_reg("R3 start", 2'd1, 16'd0);
        step(4);
        chk_reg("R3 count 4", 2'd1, 16'd4);
        check("R4 wave high", {15'd0, wave_out}, 16'd1);
        step(1);
        chk_reg("R3 wrap", 2'd1, 16'd0);
        check("R4 wave low", {15'd0, wave_out}, 16'd0);
        check("R7 irq pulse", {15'd0, irq}, 16'd1);
        check("R11 roll", {15'd0, rollover_out}, 16'd1);
        step(1);
        chk_reg("R3 after wrap", 2'd1, 16'd1);
        check("R4 wave back", {15'd0, wave_out}, 16'd1);
        check("R7 irq one clock", {15'd0, irq}, 16'd0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_irq_off;
        wr(2'd2, 16'd2);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0003);
        step(2);
        check("R11 roll no ie", {15'd0, rollover_out}, 16'd1);
        check("R7 irq masked", {15'd0, irq}, 16'd0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_dual;
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd2);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0027);
        check("R5 A phase status", {15'd0, cmp_b_active}, 16'd0);
        check("R5 A phase wave", {15'd0, wave_out}, 16'd1);
        step(2);
        chk_reg("R5 count 2", 2'd1, 16'd2);
        step(1);
        chk_reg("R5 A match count", 2'd1, 16'd0);
        check("R5 B phase status", {15'd0, cmp_b_active}, 16'd1);
        check("R5 B phase wave", {15'd0, wave_out}, 16'd0);
        check("R7 irq A", {15'd0, irq}, 16'd1);
        chk_reg("R2 status bit", 2'd0, 16'h0067);
        step(1);
        check("R5 wave stays low", {15'd0, wave_out}, 16'd0);
        step(1);
        check("R5 back to A", {15'd0, cmp_b_active}, 16'd0);
        check("R5 wave high again", {15'd0, wave_out}, 16'd1);
        check("R7 irq B", {15'd0, irq}, 16'd1);
        step(3);
        check("R5 second A match", {15'd0, cmp_b_active}, 16'd1);
        wr(2'd0, 16'h0027);
        check("R12 ctl write resets phase", {15'd0, cmp_b_active}, 16'd0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_one_pass;
        wr(2'd2, 16'd3);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0001);
        step(3);
        check("R6 single match", {15'd0, rollover_out}, 16'd1);
        chk_reg("R6 single en cleared", 2'd0, 16'h0000);
        step(3);
        chk_reg("R6 single held", 2'd1, 16'd0);
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd2);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0005);
        step(2);
        chk_reg("R6 dual en after A", 2'd0, 16'h0045);
        step(2);
        chk_reg("R6 dual en after B", 2'd0, 16'h0004);
        step(2);
        chk_reg("R6 dual held", 2'd1, 16'd0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_zero_cmp;
        wr(2'd2, 16'd0);
        wr(2'd1, 16'hFFFD);
        wr(2'd0, 16'h0003);
        step(2);
        chk_reg("R8 reaches FFFF", 2'd1, 16'hFFFF);
        check("R8 no early match", {15'd0, rollover_out}, 16'd0);
        step(1);
        chk_reg("R8 wrap", 2'd1, 16'd0);
        check("R8 match", {15'd0, rollover_out}, 16'd1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_sources;
        wr(2'd2, 16'd100);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h000B);
        step(3);
        chk_reg("R9 presc none yet", 2'd1, 16'd0);
        step(1);
        chk_reg("R9 presc 1", 2'd1, 16'd1);
        step(4);
        chk_reg("R9 presc 2", 2'd1, 16'd2);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0013);
        for (int i = 0; i < 3; i++) begin
            ext_in = 1'b1; step(3);
            ext_in = 1'b0; step(3);
        end
        step(4);
        chk_reg("R9 ext edges", 2'd1, 16'd3);
        ext_in = 1'b1; step(10);
        ext_in = 1'b0; step(4);
        chk_reg("R9 ext level once", 2'd1, 16'd4);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h001B);
        for (int i = 0; i < 4; i++) begin
            casc_in = 1'b1; step(1);
            casc_in = 1'b0; step(2);
        end
        chk_reg("R9 cascade", 2'd1, 16'd4);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_hold;
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'd7);
        for (int i = 0; i < 2; i++) begin
            ext_in = 1'b1; step(3);
            ext_in = 1'b0; step(3);
        end
        step(5);
        chk_reg("R10 hold disabled", 2'd1, 16'd7);
        wr(2'd0, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        step(1);
        t_reset;
        t_regs;
        t_single;
        t_irq_off;
        t_dual;
        t_one_pass;
        t_zero_cmp;
        t_sources;
        t_hold;
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule